// File: doc/BRIEF.md
# Early-Exit Vector Element Sequencer

This block runs a hardware for-loop over the element indices of a short vector. A start pulse hands it a vector length and three register base offsets: two sources and one target. It then steps the index from zero upward, one element per clock. At each index it presents two source register addresses to an external register file and adds the two values it reads back. It writes the sum to the target register at the same offset.

A selectable test is applied to every element sum. When the early-exit mode is armed and the test holds for an element, the loop stops at that element and does not write its sum. The reported vector length is cut to that element's index, so it counts only the elements that were written. When the mode is off, or no element trips the test, every element is written and the reported length equals the requested one. The final length is valid only from the done pulse onward, because it can change while the loop runs.

Top module: `ffseq_top`

## Requirements
- R1: Elements are processed in strictly ascending index order, one element per clock, starting at index 0.
- R2: Element i reads register addresses (ra_base+i) and (rb_base+i), and writes their sum to (rt_base+i). All address and data arithmetic wraps modulo the register count and the data width.
- R3: With ff_en high, the first element i whose sum satisfies the selected test ends the loop, and vl_out becomes i.
- R4: The failing element's sum is not written, and no element after it is read or written.
- R5: test_sel encodes the test as follows: 0 is sum equal to zero, 1 is sum non-zero, 2 is sum negative (top bit set), and 3 is sum positive (top bit clear and non-zero).
- R6: With ff_en low, or when no element satisfies the test, vl_out equals the requested length and all of its elements are written.
- R7: A requested length of zero raises done on the clock after start and performs no write.
- R8: done is a one-cycle pulse that arrives n+1 clocks after start is sampled, where n is the number of elements evaluated. vl_out keeps its value after done until the next start.
- R9: After reset, done, wr_en and busy are low and vl_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop; sampled only while idle |
| vl_in | input | VL_W | Requested vector length |
| ff_en | input | 1 | Arms the early-exit test |
| test_sel | input | 2 | Test selection, encoded as in R5 |
| ra_base | input | ADDR_W | First source base register |
| rb_base | input | ADDR_W | Second source base register |
| rt_base | input | ADDR_W | Target base register |
| rd_a_addr | output | ADDR_W | First source read address |
| rd_b_addr | output | ADDR_W | Second source read address |
| rd_a_data | input | DATA_W | First source read data (combinational) |
| rd_b_data | input | DATA_W | Second source read data (combinational) |
| wr_en | output | 1 | Element write strobe |
| wr_addr | output | ADDR_W | Element write address |
| wr_data | output | DATA_W | Element write data |
| vl_out | output | VL_W | Final vector length |
| done | output | 1 | Loop-finished pulse |
| busy | output | 1 | Loop in progress |

## Verification
Register contents are drawn from a narrow signed range, so that zero, negative and positive sums all turn up often. Runs with each test select and the early-exit mode on can then be told apart from runs that complete all their elements. Directed cases cover a zero length, a failure at element 0, a failure at the last element, a full-length run with the mode off even though zero sums are present, and target ranges that overlap the sources. The overlap case separates true in-order write-then-read from any batching of reads. The whole register file, the write count, the write order and the done latency are all compared against a sequential model in the bench.

// File: rtl/ffseq_pkg.sv
package ffseq_pkg;

  typedef enum logic [1:0] {
    TST_ZERO    = 2'd0,
    TST_NONZERO = 2'd1,
    TST_NEG     = 2'd2,
    TST_POS     = 2'd3
  } test_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/ffseq_elem_alu.sv
module ffseq_elem_alu
  import ffseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  test_sel_e         sel,
  output logic [DATA_W-1:0] sum,
  output logic              hit
);

  function automatic logic [DATA_W-1:0] elem_sum(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic test_hit(input logic [DATA_W-1:0] r, input test_sel_e s);
    logic is_zero;
    logic is_neg;
    is_zero = (r == '0);
    is_neg  = r[DATA_W-1];
    case (s)
      TST_ZERO:    return is_zero;
      TST_NONZERO: return !is_zero;
      TST_NEG:     return is_neg;
      default:     return !is_neg && !is_zero;
    endcase
  endfunction

  assign sum = elem_sum(op_a, op_b);
  assign hit = test_hit(sum, sel);

endmodule

// File: rtl/ffseq_addr_gen.sv
module ffseq_addr_gen #(
  parameter int ADDR_W = 5,
  parameter int VL_W   = 5,
  parameter int NPORT  = 3
) (
  input  logic [NPORT-1:0][ADDR_W-1:0] bases,
  input  logic [VL_W-1:0]              idx,
  output logic [NPORT-1:0][ADDR_W-1:0] addrs
);

  function automatic logic [ADDR_W-1:0] offset_addr(input logic [ADDR_W-1:0] b,
                                                    input logic [VL_W-1:0]   i);
    logic [ADDR_W+VL_W-1:0] wide;
    wide = (ADDR_W+VL_W)'(b) + (ADDR_W+VL_W)'(i);
    return wide[ADDR_W-1:0];
  endfunction

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign addrs[p] = offset_addr(bases[p], idx);
  end

endmodule

// File: rtl/ffseq_loop_ctrl.sv
module ffseq_loop_ctrl
  import ffseq_pkg::*;
#(
  parameter int VL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  logic            ff_en,
  input  logic            elem_hit,
  output logic            accept,
  output logic [VL_W-1:0] idx,
  output logic            elem_active,
  output logic            elem_commit,
  output logic [VL_W-1:0] vl_final,
  output logic            done,
  output logic            busy
);

  seq_state_e      state;
  logic [VL_W-1:0] vl_lim;
  logic            ff_q;
  logic            stop_fail;
  logic            last_elem;

  assign accept      = start && (state == ST_IDLE);
  assign elem_active = (state == ST_RUN);
  assign stop_fail   = elem_active && ff_q && elem_hit;
  assign last_elem   = elem_active && (idx == vl_lim - VL_W'(1));
  assign elem_commit = elem_active && !stop_fail;
  assign done        = (state == ST_FIN);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      vl_lim   <= '0;
      ff_q     <= 1'b0;
      idx      <= '0;
      vl_final <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            vl_lim <= vl_in;
            ff_q   <= ff_en;
            idx    <= '0;
            if (vl_in == '0) begin
              vl_final <= '0;
              state    <= ST_FIN;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (stop_fail) begin
            vl_final <= idx;
            state    <= ST_FIN;
          end else if (last_elem) begin
            vl_final <= vl_lim;
            state    <= ST_FIN;
          end else begin
            idx <= idx + VL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: index advances by exactly one between consecutive elements
  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_active && !stop_fail && !last_elem) |=> (elem_active && idx == $past(idx) + VL_W'(1)));

  // R3: a failing element ends the loop with length equal to its index
  assert_vl_truncate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fail |=> (done && vl_final == $past(idx)));

  // R6: final length never exceeds the requested length
  assert_vl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_final <= vl_lim));

  // R7: zero length finishes on the next clock
  assert_zero_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vl_in == '0) |=> (done && vl_final == '0));

  // R8: done lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: final length is held while idle
  assert_vl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(vl_final));

endmodule

// File: rtl/ffseq_top.sv
module ffseq_top
  import ffseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int VL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic              ff_en,
  input  logic [1:0]        test_sel,
  input  logic [ADDR_W-1:0] ra_base,
  input  logic [ADDR_W-1:0] rb_base,
  input  logic [ADDR_W-1:0] rt_base,
  output logic [ADDR_W-1:0] rd_a_addr,
  output logic [ADDR_W-1:0] rd_b_addr,
  input  logic [DATA_W-1:0] rd_a_data,
  input  logic [DATA_W-1:0] rd_b_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [VL_W-1:0]   vl_out,
  output logic              done,
  output logic              busy
);

  localparam int NPORT = 3;
  localparam int P_A   = 0;
  localparam int P_B   = 1;
  localparam int P_T   = 2;

  logic                          accept;
  logic [VL_W-1:0]               idx;
  logic                          elem_active;
  logic                          elem_commit;
  logic                          elem_hit;
  logic [DATA_W-1:0]             elem_sum;
  test_sel_e                     sel_q;
  logic [NPORT-1:0][ADDR_W-1:0]  base_q;
  logic [NPORT-1:0][ADDR_W-1:0]  addr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= TST_ZERO;
      base_q <= '0;
    end else if (accept) begin
      sel_q       <= test_sel_e'(test_sel);
      base_q[P_A] <= ra_base;
      base_q[P_B] <= rb_base;
      base_q[P_T] <= rt_base;
    end
  end

  ffseq_loop_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .vl_in       (vl_in),
    .ff_en       (ff_en),
    .elem_hit    (elem_hit),
    .accept      (accept),
    .idx         (idx),
    .elem_active (elem_active),
    .elem_commit (elem_commit),
    .vl_final    (vl_out),
    .done        (done),
    .busy        (busy)
  );

  ffseq_addr_gen #(.ADDR_W(ADDR_W), .VL_W(VL_W), .NPORT(NPORT)) u_addr (
    .bases (base_q),
    .idx   (idx),
    .addrs (addr_vec)
  );

  ffseq_elem_alu #(.DATA_W(DATA_W)) u_alu (
    .op_a (rd_a_data),
    .op_b (rd_b_data),
    .sel  (sel_q),
    .sum  (elem_sum),
    .hit  (elem_hit)
  );

  assign rd_a_addr = addr_vec[P_A];
  assign rd_b_addr = addr_vec[P_B];
  assign wr_addr   = addr_vec[P_T];
  assign wr_data   = elem_sum;
  assign wr_en     = elem_commit;

  // R4: nothing is written once the loop has finished
  assert_no_write_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R7: writes only occur inside a loop
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  // R2: the write carries the sum of the two read ports
  assert_write_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == DATA_W'(rd_a_data + rd_b_data)));

endmodule

// File: tb/ffseq_top_tb_top.sv
module ffseq_top_tb_top;

  localparam int DW = 16;
  localparam int AW = 5;
  localparam int VW = 5;
  localparam int NREG = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] vl_in = '0;
  logic          ff_en = 1'b0;
  logic [1:0]    test_sel = '0;
  logic [AW-1:0] ra_base = '0, rb_base = '0, rt_base = '0;
  logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en, done, busy;
  logic [VW-1:0] vl_out;

  logic [DW-1:0] rf [NREG];
  int            wr_count = 0;
  int            wr_k = 0;
  int            order_bad = 0;
  int            checks = 0;
  int            fails = 0;

  always #10 clk = ~clk;

  ffseq_top #(.DATA_W(DW), .ADDR_W(AW), .VL_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .ff_en(ff_en),
    .test_sel(test_sel), .ra_base(ra_base), .rb_base(rb_base), .rt_base(rt_base),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .rd_a_data(rd_a_data),
    .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vl_out(vl_out), .done(done), .busy(busy)
  );

  assign rd_a_data = rf[rd_a_addr];
  assign rd_b_data = rf[rd_b_addr];

  // register file model plus write-order monitor (R1, R2)
  always @(posedge clk) begin
    if (wr_en) begin
      rf[wr_addr] <= wr_data;
      if (wr_addr != AW'(int'(rt_base) + wr_k) ||
          rd_a_addr != AW'(int'(ra_base) + wr_k) ||
          rd_b_addr != AW'(int'(rb_base) + wr_k))
        order_bad = order_bad + 1;
      wr_k = wr_k + 1;
      wr_count = wr_count + 1;
    end
  end

  function automatic bit ref_test(input logic [DW-1:0] r, input int sel);
    int sv;
    sv = int'($signed(r));
    if (sel == 0) return sv == 0;
    if (sel == 1) return sv != 0;
    if (sel == 2) return sv < 0;
    return sv > 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_rf(input int lo, input int hi);
    for (int r = 0; r < NREG; r++) rf[r] = DW'($urandom_range(hi - lo) + lo);
  endtask

  task automatic run_case(input int vl, input int sel, input bit ff,
                          input int ra, input int rb, input int rt);
    logic [DW-1:0] m [NREG];
    int n_eval, fvl, nwr, edges;
    bit failed;
    logic [DW-1:0] r;
    for (int k = 0; k < NREG; k++) m[k] = rf[k];
    n_eval = 0; fvl = vl; nwr = 0; failed = 0;
    for (int i = 0; i < vl; i++) begin
      r = m[(ra + i) % NREG] + m[(rb + i) % NREG];
      n_eval++;
      if (ff && ref_test(r, sel)) begin
        fvl = i; failed = 1;
        break;
      end
      m[(rt + i) % NREG] = r;
      nwr++;
    end
    @(negedge clk);
    wr_count = 0; wr_k = 0; order_bad = 0;
    vl_in = VW'(vl); test_sel = 2'(sel); ff_en = ff;
    ra_base = AW'(ra); rb_base = AW'(rb); rt_base = AW'(rt);
    start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && edges < 100) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    check(edges == n_eval + 1, vl == 0 ? "R7 done latency" : "R8 done latency", edges, n_eval + 1);
    if (failed) check(vl_out == VW'(fvl), "R3 truncated length", int'(vl_out), fvl);
    else        check(vl_out == VW'(fvl), "R6 full length", int'(vl_out), fvl);
    check(wr_count == nwr, failed ? "R4 write count" : "R6 write count", wr_count, nwr);
    check(order_bad == 0, "R1 ascending element order", order_bad, 0);
    for (int k = 0; k < NREG; k++)
      if (rf[k] !== m[k]) begin
        check(0, "R2 register contents", int'(rf[k]), int'(m[k]));
        break;
      end
    checks++;
    @(negedge clk);
    check(done == 1'b0, "R8 done pulse width", int'(done), 0);
    check(vl_out == VW'(fvl), "R8 length held", int'(vl_out), fvl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NREG; r++) rf[r] = '0;
    repeat (3) @(negedge clk);
    check(done == 0 && wr_en == 0 && busy == 0, "R9 reset outputs", int'({done, wr_en, busy}), 0);
    check(vl_out == 0, "R9 reset length", int'(vl_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: zero length
    fill_rf(-3, 3);
    run_case(0, 0, 1, 0, 8, 16);
    // R4: fail at element 0 (zero test on a zero sum)
    rf[2] = 16'd5; rf[10] = 16'hFFFB;
    run_case(6, 0, 1, 2, 10, 20);
    // R6: ff off with zero sums present, full length 31
    for (int r = 0; r < NREG; r++) rf[r] = '0;
    run_case(31, 0, 0, 0, 1, 3);
    // R3: fail on the last element, negative test
    for (int r = 0; r < NREG; r++) rf[r] = 16'd1;
    rf[7] = 16'hFFF0;
    run_case(8, 2, 1, 0, 16, 24);
    // R5: positive test never trips on non-positive sums
    for (int r = 0; r < NREG; r++) rf[r] = 16'hFFFF;
    run_case(10, 3, 1, 4, 5, 20);
    // R5: non-zero test on first element
    fill_rf(1, 4);
    run_case(5, 1, 1, 0, 1, 10);
    // R2: target overlaps the sources, in-order read after write
    fill_rf(0, 3);
    run_case(12, 0, 0, 0, 3, 1);

    for (int t = 0; t < 60; t++) begin
      fill_rf(-4, 4);
      run_case($urandom_range(31), $urandom_range(3), $urandom_range(3) != 0,
               $urandom_range(31), $urandom_range(31), $urandom_range(31));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule